// File: doc/BRIEF.md
# Endpoint Configuration Image Loader

After power-up, software must load a fixed configuration image into a set of per-endpoint configuration buffers before the endpoints can run. The image arrives one byte at a time on a byte-wide write strobe. This block takes those bytes in order and places each one in its position in the buffer array. The array has seventeen buffers of forty bits each, so a full image is eighty-five bytes. Each buffer fills from its most significant byte down, and then the next buffer starts.

All buffers are held in registers and are driven out together as one flat parallel bus. Buffer `b` occupies bits `b*40 +: 40`. When the last byte of the image has been stored, a done flag rises. Once done is set, further bytes are dropped. They stay dropped until a reload request or a reset rewinds the byte position. A reload keeps the stored contents, so a new image overwrites them byte by byte.

Top module: `cfg_image_loader`

## Requirements
- R1: A synchronous active-high `rst` clears every buffer bit to zero, clears `cfg_done`, and rewinds the byte position to the first byte.
- R2: The first byte accepted after reset or reload is stored in bits 39:32 of buffer 0, that is `buf_flat[39:32]`.
- R3: The accepted byte with index n (counting from 0) is stored in buffer n/5, in bits `(39-8*(n%5)) -: 8` of that buffer, which is `buf_flat[(n/5)*40 + 39 - 8*(n%5) -: 8]`. Buffers fill from the top byte downward and in rising buffer order.
- R4: A byte strobed with `wr_en` high on a clock edge appears on `buf_flat` right after that edge. No other byte of `buf_flat` changes on that edge.
- R5: `cfg_done` rises right after the edge that stores byte index 84, the 85th byte. It is low before that edge.
- R6: While `cfg_done` is high, `wr_en` strobes leave `buf_flat` unchanged.
- R7: `reload` clears `cfg_done` and rewinds the byte position to the first byte. It leaves the `buf_flat` contents as they were. The next accepted byte goes to `buf_flat[39:32]`.
- R8: When `reload` and `wr_en` are high on the same edge, the reload takes effect and the byte is not stored.
- R9: With `wr_en` low, `buf_flat` holds its value and the byte position does not advance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe, one byte per high cycle |
| wr_data | input | 8 | Byte to store |
| reload | input | 1 | Rewind the byte position and clear done |
| buf_flat | output | 680 | All 17 buffers; buffer b at bits b*40 +: 40 |
| cfg_done | output | 1 | High once the full 85-byte image is stored |

## Verification
The assertions take for granted that `rst` is applied before the first strobe that matters. They also assume all inputs are at known levels on every clock edge, so the history they read through `$past` is defined.

The stimulus meets both conditions. It holds reset for several cycles and changes inputs only on falling edges. It walks a complete arithmetic image through every byte position. It then probes strobes after done, a reload colliding with a write, and a partial reload that overwrites some bytes and leaves the rest untouched.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  localparam int BYTE_W = 8;

  // Bit offset of a byte lane inside one buffer; lane 0 is the top byte.
  function automatic int lane_lsb(input int lane, input int bytes_per_buf);
    return (bytes_per_buf - 1 - lane) * BYTE_W;
  endfunction
endpackage

// File: rtl/cfg_byte_sequencer.sv
module cfg_byte_sequencer #(
  parameter int NUM_BUF       = 17,
  parameter int BYTES_PER_BUF = 5,
  localparam int TOTAL  = NUM_BUF * BYTES_PER_BUF,
  localparam int CNT_W  = $clog2(TOTAL + 1),
  localparam int IDX_W  = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1,
  localparam int LANE_W = (BYTES_PER_BUF > 1) ? $clog2(BYTES_PER_BUF) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              reload,
  output logic              accept,
  output logic [IDX_W-1:0]  buf_idx,
  output logic [LANE_W-1:0] lane,
  output logic              done
);
  logic [CNT_W-1:0] count_q;
  logic [IDX_W-1:0] idx_q;
  logic [LANE_W-1:0] lane_q;
  logic done_q;
  logic last_lane, last_byte;

  assign accept    = wr_en && !done_q && !reload;
  assign last_lane = (lane_q == LANE_W'(BYTES_PER_BUF - 1));
  assign last_byte = (count_q == CNT_W'(TOTAL - 1));

  always_ff @(posedge clk) begin
    if (rst || reload) begin
      count_q <= '0;
      idx_q   <= '0;
      lane_q  <= '0;
      done_q  <= 1'b0;
    end else if (accept) begin
      count_q <= count_q + 1'b1;
      if (last_byte)
        done_q <= 1'b1;
      if (last_lane) begin
        lane_q <= '0;
        idx_q  <= idx_q + 1'b1;
      end else begin
        lane_q <= lane_q + 1'b1;
      end
    end
  end

  assign buf_idx = idx_q;
  assign lane    = lane_q;
  assign done    = done_q;

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    count_q <= CNT_W'(TOTAL)); // R5
  AST_DONE_AT_FULL: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> (count_q == CNT_W'(TOTAL))); // R5
  AST_RELOAD_REWINDS: assert property (@(posedge clk) disable iff (rst)
    reload |=> (count_q == '0 && !done_q && lane_q == '0 && idx_q == '0)); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !reload) |=> $stable(count_q)); // R9
  AST_LANE_RANGE: assert property (@(posedge clk) disable iff (rst)
    lane_q < LANE_W'(BYTES_PER_BUF)); // R3
endmodule

// File: rtl/cfg_buf_bank.sv
module cfg_buf_bank
  import cfg_loader_pkg::*;
#(
  parameter int NUM_BUF       = 17,
  parameter int BYTES_PER_BUF = 5,
  localparam int BUF_W  = BYTES_PER_BUF * BYTE_W,
  localparam int FLAT_W = NUM_BUF * BUF_W,
  localparam int LANES  = NUM_BUF * BYTES_PER_BUF,
  localparam int IDX_W  = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1,
  localparam int LANE_W = (BYTES_PER_BUF > 1) ? $clog2(BYTES_PER_BUF) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  buf_idx,
  input  logic [LANE_W-1:0] lane,
  input  logic [BYTE_W-1:0] din,
  output logic [FLAT_W-1:0] bufs
);
  logic [LANES-1:0] lane_we;

  for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
    for (genvar l = 0; l < BYTES_PER_BUF; l++) begin : g_lane
      localparam int LSB = b * BUF_W + lane_lsb(l, BYTES_PER_BUF);
      assign lane_we[b*BYTES_PER_BUF + l] =
        we && (buf_idx == IDX_W'(b)) && (lane == LANE_W'(l));
      always_ff @(posedge clk) begin
        if (rst)
          bufs[LSB +: BYTE_W] <= '0;
        else if (lane_we[b*BYTES_PER_BUF + l])
          bufs[LSB +: BYTE_W] <= din;
      end
    end
  end

  AST_SINGLE_LANE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lane_we)); // R4
  AST_RESET_ZERO: assert property (@(posedge clk)
    $past(rst) |-> (bufs == '0)); // R1
  AST_NO_WE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(bufs)); // R9
endmodule

// File: rtl/cfg_image_loader.sv
module cfg_image_loader #(
  parameter int NUM_BUF       = 17,
  parameter int BYTES_PER_BUF = 5,
  localparam int BUF_W  = BYTES_PER_BUF * 8,
  localparam int FLAT_W = NUM_BUF * BUF_W,
  localparam int IDX_W  = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1,
  localparam int LANE_W = (BYTES_PER_BUF > 1) ? $clog2(BYTES_PER_BUF) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  input  logic              reload,
  output logic [FLAT_W-1:0] buf_flat,
  output logic              cfg_done
);
  logic              accept;
  logic [IDX_W-1:0]  buf_idx;
  logic [LANE_W-1:0] lane;

  cfg_byte_sequencer #(.NUM_BUF(NUM_BUF), .BYTES_PER_BUF(BYTES_PER_BUF)) u_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .reload(reload),
    .accept(accept), .buf_idx(buf_idx), .lane(lane), .done(cfg_done)
  );

  cfg_buf_bank #(.NUM_BUF(NUM_BUF), .BYTES_PER_BUF(BYTES_PER_BUF)) u_bank (
    .clk(clk), .rst(rst), .we(accept), .buf_idx(buf_idx), .lane(lane),
    .din(wr_data), .bufs(buf_flat)
  );

  AST_IGNORE_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    cfg_done |=> $stable(buf_flat)); // R6
  AST_RELOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    reload |=> $stable(buf_flat)); // R8
  AST_RELOAD_CLEARS_DONE: assert property (@(posedge clk) disable iff (rst)
    reload |=> !cfg_done); // R7
  AST_FIRST_TOP_BYTE: assert property (@(posedge clk) disable iff (rst)
    ($past(reload) && wr_en && !reload) |=> (buf_flat[BUF_W-1 -: 8] == $past(wr_data))); // R2
endmodule

// File: tb/cfg_image_loader_test.sv
module cfg_image_loader_test;
  localparam int NB = 17, BPB = 5, TOTAL = NB * BPB, BW = BPB * 8;

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, reload = 1'b0;
  logic [7:0] wr_data = '0;
  logic [NB*BW-1:0] buf_flat;
  logic cfg_done;
  int n_chk = 0, n_bad = 0;
  logic [7:0] model [TOTAL];

  always #4 clk = ~clk;

  cfg_image_loader #(.NUM_BUF(NB), .BYTES_PER_BUF(BPB)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .reload(reload),
    .buf_flat(buf_flat), .cfg_done(cfg_done)
  );

  function automatic logic [7:0] pat_a(int n); return 8'((n * 37 + 11) & 255); endfunction
  function automatic logic [7:0] pat_b(int n); return 8'((n * 91 + 200) & 255); endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [BW-1:0] model_buf(int b);
    logic [BW-1:0] w;
    for (int l = 0; l < BPB; l++) w[BW-1-8*l -: 8] = model[b*BPB + l];
    return w;
  endfunction

  task automatic write_byte(logic [7:0] d, logic with_reload);
    @(negedge clk); wr_en = 1'b1; wr_data = d; reload = with_reload;
    @(negedge clk); wr_en = 1'b0; reload = 1'b0;
  endtask

  task automatic check_all(string req);
    for (int b = 0; b < NB; b++) chk(req, 64'(buf_flat[b*BW +: BW]), 64'(model_buf(b)));
  endtask

  initial begin
    #1_600_000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < TOTAL; i++) model[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset buffers", 64'(buf_flat == '0), 64'd1);
    chk("R1 reset done", 64'(cfg_done), 64'd0);

    // First byte lands in the top byte of buffer 0, nothing else moves.
    write_byte(pat_a(0), 1'b0); model[0] = pat_a(0);
    chk("R2 first byte", 64'(buf_flat[39:32]), 64'(pat_a(0)));
    chk("R4 other bytes", 64'(buf_flat[NB*BW-1:40] == '0 && buf_flat[31:0] == '0), 64'd1);

    // Idle cycles: no change.
    repeat (3) @(negedge clk);
    check_all("R9 idle hold");

    for (int n = 1; n < TOTAL; n++) begin
      write_byte(pat_a(n), 1'b0); model[n] = pat_a(n);
      chk("R3 byte slot", 64'(buf_flat[(n/BPB)*BW + BW-1 - 8*(n%BPB) -: 8]), 64'(pat_a(n)));
      if (n == TOTAL - 2) chk("R5 done low before last", 64'(cfg_done), 64'd0);
    end
    chk("R5 done after last", 64'(cfg_done), 64'd1);
    check_all("R3 full image");

    // Strobes after done are dropped.
    write_byte(8'h5A, 1'b0);
    write_byte(8'hA5, 1'b0);
    check_all("R6 ignore after done");
    chk("R6 done stays", 64'(cfg_done), 64'd1);

    // Reload with a colliding write: write not stored.
    write_byte(8'hEE, 1'b1);
    chk("R7 done cleared", 64'(cfg_done), 64'd0);
    check_all("R8 reload wins");

    // Partial new image overwrites only the leading bytes.
    for (int n = 0; n < 7; n++) begin
      write_byte(pat_b(n), 1'b0); model[n] = pat_b(n);
    end
    chk("R7 restart at top byte", 64'(buf_flat[39:32]), 64'(pat_b(0)));
    check_all("R7 partial reload keeps rest");
    chk("R5 done low mid-load", 64'(cfg_done), 64'd0);

    // Reset clears everything.
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < TOTAL; i++) model[i] = 8'h00;
    check_all("R1 reset clears");
    chk("R1 done after reset", 64'(cfg_done), 64'd0);
    write_byte(8'h3C, 1'b0);
    chk("R1 position rewound", 64'(buf_flat[39:32]), 64'h3C);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule